// File: doc/BRIEF.md
# Burst Read Address Sequencer

This block produces the word addresses for a synchronous burst read from a word-addressed memory array of 4M sixteen-bit words. A one-cycle start strobe captures a start address and a configuration: a burst length of four words, eight words or continuous, a wrap bit, and a latency count. On the next clock the first word address is presented with a data-valid strobe. Each cycle in which the word is valid and the advance strobe is high moves the sequence on by one word.

In wrap mode a fixed-length burst stays inside its aligned four- or eight-word group. In no-wrap mode, and always in continuous mode, the address counts up linearly and rolls over from the last array word to zero. A linear sequence that crosses the first eight-word boundary after the start stalls once. The stall lasts the smaller of the latency count and the start word's offset k within its eight-word group. During the stall the active-low WAIT output is low and data-valid is low.

The controller has three named states. IDLE holds no burst. DATA presents a valid word. STALL holds the boundary delay. The transitions are: START (any state to DATA, on the start strobe), STEP (DATA to DATA on advance), FINISH (DATA to IDLE when the last word of a fixed-length burst is advanced), ENTER_STALL (DATA to STALL when the advance crosses the first eight-word boundary and the stall length is not zero), and RESUME (STALL to DATA when the stall count runs out).

Top module: `burst_addr_seq`

## Requirements
- R1: One clock after a cycle with `start` high, `addr` equals the captured `start_addr`, `valid` is 1 and `wait_n` is 1. This holds even if a burst was in progress, which is then abandoned.
- R2: While `valid` is 1, a clock with `advance` high presents the next word of the sequence. A clock with `advance` low keeps the same word.
- R3: `len_sel` 2'b00 selects four words and 2'b01 selects eight words. After the last word of a fixed-length burst is advanced, `valid` goes to 0 and stays 0 until the next start.
- R4: With `no_wrap` = 0 and a fixed length, the address wraps inside its aligned group: start 1 of four gives 1,2,3,0; start 5 gives 5,6,7,4; start 13 of eight gives 13,14,15,8..12.
- R5: With `no_wrap` = 0 and a fixed length, `wait_n` stays 1 for the whole burst.
- R6: With `no_wrap` = 1 and a fixed length, the address counts up by one across group boundaries, for example 2,3,4,5 or 7,8,9,10.
- R7: `len_sel` 2'b10 or 2'b11 selects continuous mode. The address counts up by one until a new start, ignoring `no_wrap`, and rolls over from 22'h3FFFFF to 0.
- R8: In linear sequences, the advance that crosses the first eight-word boundary after the start inserts min(`latency`, k) cycles with `wait_n` = 0 and `valid` = 0 before the boundary word becomes valid. Here k is `start_addr[2:0]`.
- R9: The boundary stall happens at most once per burst. There is none when k = 0, when `latency` = 0, or when the sequence never crosses an eight-word boundary.
- R10: After reset, `valid` = 0, `wait_n` = 1 and `addr` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a new burst; captures address and configuration |
| start_addr | input | 22 | First word address of the burst |
| len_sel | input | 2 | 00 four words, 01 eight words, 1x continuous |
| no_wrap | input | 1 | 0 wrap within group, 1 linear |
| latency | input | 4 | Latency count, upper bound on the boundary stall |
| advance | input | 1 | Consume the current valid word |
| addr | output | 22 | Current word address |
| valid | output | 1 | Current address holds a word to consume |
| wait_n | output | 1 | Low while the boundary stall lasts |

## Verification
Wrapped bursts starting at unaligned offsets tell group wrapping apart from linear counting, and they must show no stall. Linear bursts starting at offsets 0, 2, 3, 5, 6 and 7 and with latencies on both sides of k tell the min(latency, k) stall length apart from a fixed latency or offset stall. A four-word burst that stays inside its group checks that the stall really depends on crossing the boundary. Continuous bursts that cross two boundaries and wrap past the top of the array show that the stall happens once and that the address rolls over. A burst with advance toggling and starts issued mid-burst exercise holding and aborting.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_DATA  = 2'd1,
        ST_STALL = 2'd2
    } seq_state_e;

    typedef enum logic [1:0] {
        LEN_FOUR  = 2'b00,
        LEN_EIGHT = 2'b01,
        LEN_CONT  = 2'b10,
        LEN_CONTX = 2'b11
    } len_mode_e;

    localparam int unsigned GROUP_BITS = 3;

    function automatic logic is_continuous(len_mode_e m);
        return (m == LEN_CONT) || (m == LEN_CONTX);
    endfunction

    function automatic logic [3:0] burst_words(len_mode_e m);
        return (m == LEN_FOUR) ? 4'd4 : 4'd8;
    endfunction

endpackage

// File: rtl/bseq_next_addr.sv
module bseq_next_addr
    import burst_seq_pkg::*;
#(
    parameter int unsigned ADDR_W = 22
) (
    input  logic [ADDR_W-1:0] cur,
    input  len_mode_e         mode,
    input  logic              linear,
    output logic [ADDR_W-1:0] nxt
);

    localparam int unsigned FOUR_BITS  = 2;
    localparam int unsigned EIGHT_BITS = GROUP_BITS;

    logic [ADDR_W-1:0] lin_nxt;
    logic [ADDR_W-1:0] wrap4_nxt;
    logic [ADDR_W-1:0] wrap8_nxt;

    // full-width increment: rollover from the top word to zero is natural
    assign lin_nxt = cur + ADDR_W'(1);

    generate
        if (ADDR_W > EIGHT_BITS) begin : g_wide
            assign wrap4_nxt = {cur[ADDR_W-1:FOUR_BITS],
                                FOUR_BITS'(cur[FOUR_BITS-1:0] + 1'b1)};
            assign wrap8_nxt = {cur[ADDR_W-1:EIGHT_BITS],
                                EIGHT_BITS'(cur[EIGHT_BITS-1:0] + 1'b1)};
        end else begin : g_narrow
            assign wrap4_nxt = lin_nxt;
            assign wrap8_nxt = lin_nxt;
        end
    endgenerate

    always_comb begin
        if (linear) begin
            nxt = lin_nxt;
        end else begin
            unique case (mode)
                LEN_FOUR:  nxt = wrap4_nxt;
                LEN_EIGHT: nxt = wrap8_nxt;
                default:   nxt = lin_nxt;
            endcase
        end
    end

endmodule

// File: rtl/bseq_stall_len.sv
module bseq_stall_len
    import burst_seq_pkg::*;
#(
    parameter int unsigned LAT_W = 4
) (
    input  logic [GROUP_BITS-1:0] offset,
    input  logic [LAT_W-1:0]      lat,
    output logic [LAT_W-1:0]      stall_len
);

    localparam int unsigned CMP_W = (LAT_W > GROUP_BITS) ? LAT_W : GROUP_BITS;

    logic [CMP_W-1:0] off_w;
    logic [CMP_W-1:0] lat_w;
    logic [CMP_W-1:0] min_w;

    assign off_w = CMP_W'(offset);
    assign lat_w = CMP_W'(lat);

    // stall is the smaller of the latency setting and the start offset
    always_comb begin
        if (lat_w < off_w) min_w = lat_w;
        else               min_w = off_w;
    end

    assign stall_len = LAT_W'(min_w);

endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
    import burst_seq_pkg::*;
#(
    parameter int unsigned ADDR_W = 22,
    parameter int unsigned LAT_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [1:0]        len_sel,
    input  logic              no_wrap,
    input  logic [LAT_W-1:0]  latency,
    input  logic              advance,
    output logic [ADDR_W-1:0] addr,
    output logic              valid,
    output logic              wait_n
);

    localparam int unsigned CNT_W = 4;

    seq_state_e            state_q, state_d;
    logic [ADDR_W-1:0]     addr_q, addr_d;
    logic [CNT_W-1:0]      left_q, left_d;
    logic [LAT_W-1:0]      stl_q, stl_d;
    logic                  crossed_q, crossed_d;
    len_mode_e             mode_q, mode_d;
    logic                  nowrap_q, nowrap_d;
    logic [LAT_W-1:0]      lat_q, lat_d;
    logic [GROUP_BITS-1:0] off_q, off_d;

    logic                  cont;
    logic                  linear;
    logic                  last_word;
    logic                  crossing;
    logic [ADDR_W-1:0]     nxt_addr;
    logic [LAT_W-1:0]      stall_len;

    assign cont      = is_continuous(mode_q);
    assign linear    = cont || nowrap_q;
    assign last_word = !cont && (left_q == CNT_W'(1));
    assign crossing  = linear && !crossed_q &&
                       (nxt_addr[GROUP_BITS-1:0] == '0);

    bseq_next_addr #(.ADDR_W(ADDR_W)) u_next (
        .cur    (addr_q),
        .mode   (mode_q),
        .linear (linear),
        .nxt    (nxt_addr)
    );

    bseq_stall_len #(.LAT_W(LAT_W)) u_stall (
        .offset    (off_q),
        .lat       (lat_q),
        .stall_len (stall_len)
    );

    // next-state logic
    always_comb begin
        state_d   = state_q;
        addr_d    = addr_q;
        left_d    = left_q;
        stl_d     = stl_q;
        crossed_d = crossed_q;
        mode_d    = mode_q;
        nowrap_d  = nowrap_q;
        lat_d     = lat_q;
        off_d     = off_q;
        if (start) begin
            // START: reload everything, abandoning any burst in progress
            state_d   = ST_DATA;
            addr_d    = start_addr;
            mode_d    = len_mode_e'(len_sel);
            nowrap_d  = no_wrap;
            lat_d     = latency;
            off_d     = start_addr[GROUP_BITS-1:0];
            left_d    = burst_words(len_mode_e'(len_sel));
            crossed_d = 1'b0;
            stl_d     = '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    state_d = ST_IDLE;
                end
                ST_DATA: begin
                    if (advance) begin
                        if (last_word) begin
                            state_d = ST_IDLE;          // FINISH
                        end else begin
                            addr_d = nxt_addr;          // STEP
                            if (!cont) left_d = left_q - CNT_W'(1);
                            if (crossing) begin
                                crossed_d = 1'b1;
                                if (stall_len != '0) begin
                                    state_d = ST_STALL; // ENTER_STALL
                                    stl_d   = stall_len;
                                end
                            end
                        end
                    end
                end
                ST_STALL: begin
                    stl_d = stl_q - LAT_W'(1);
                    if (stl_q == LAT_W'(1)) state_d = ST_DATA;  // RESUME
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            addr_q    <= '0;
            left_q    <= '0;
            stl_q     <= '0;
            crossed_q <= 1'b0;
            mode_q    <= LEN_FOUR;
            nowrap_q  <= 1'b0;
            lat_q     <= '0;
            off_q     <= '0;
        end else begin
            state_q   <= state_d;
            addr_q    <= addr_d;
            left_q    <= left_d;
            stl_q     <= stl_d;
            crossed_q <= crossed_d;
            mode_q    <= mode_d;
            nowrap_q  <= nowrap_d;
            lat_q     <= lat_d;
            off_q     <= off_d;
        end
    end

    // outputs
    always_comb begin
        addr = addr_q;
        unique case (state_q)
            ST_IDLE: begin
                valid  = 1'b0;
                wait_n = 1'b1;
            end
            ST_DATA: begin
                valid  = 1'b1;
                wait_n = 1'b1;
            end
            ST_STALL: begin
                valid  = 1'b0;
                wait_n = 1'b0;
            end
            default: begin
                valid  = 1'b0;
                wait_n = 1'b1;
            end
        endcase
    end

    // ---------------- assertions ----------------
    AST_START_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (valid && wait_n && addr == $past(start_addr))); // R1

    AST_HOLD_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !advance && !start) |=> (valid && $stable(addr))); // R2

    AST_WRAP_IN_GROUP: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && advance && !start && !linear && !last_word)
        |=> (addr[ADDR_W-1:GROUP_BITS] == $past(addr[ADDR_W-1:GROUP_BITS]))); // R4

    AST_WRAP_NO_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE && !linear) |-> wait_n); // R5

    AST_LINEAR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && advance && !start && linear && !last_word)
        |=> (addr == ADDR_W'($past(addr) + ADDR_W'(1)))); // R6

    AST_STALL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (!wait_n) |-> (stl_q <= lat_q && CNT_W'(stl_q) <= CNT_W'(off_q))); // R8

    AST_STALL_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        (crossed_q && valid && !start) |=> wait_n); // R9

    AST_NO_VALID_IN_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (!wait_n) |-> !valid); // R8

endmodule

// File: tb/sim_burst_addr_seq.sv
module sim_burst_addr_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [21:0] start_addr = '0;
    logic [1:0]  len_sel = '0;
    logic        no_wrap = 1'b0;
    logic [3:0]  latency = '0;
    logic        advance = 1'b0;
    logic [21:0] addr;
    logic        valid;
    logic        wait_n;

    int checks = 0;
    int errors = 0;
    int wait_seen = 0;
    bit strict = 1'b0;
    bit adv_toggle = 1'b0;
    bit mon_on = 1'b0;
    logic [21:0] exp_q[$];
    string       tag_q[$];

    always #10 clk = ~clk;   // 50 MHz

    burst_addr_seq u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
        .len_sel(len_sel), .no_wrap(no_wrap), .latency(latency),
        .advance(advance), .addr(addr), .valid(valid), .wait_n(wait_n)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // monitor: drives advance and compares words as they are consumed
    always @(negedge clk) begin
        if (mon_on) begin
            advance = adv_toggle ? ~advance : 1'b1;
            if (!wait_n) wait_seen++;
            if (valid && advance) begin
                if (exp_q.size() > 0) begin
                    logic [21:0] e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    check(addr == e, t, addr, e);
                end else if (strict) begin
                    check(1'b0, "R3 extra word", addr, 0);
                end
            end
        end
    end

    // driver: builds the expected sequence and stall from the requirements
    task automatic run(input logic [21:0] sa, input logic [1:0] ls, input bit nw,
                       input logic [3:0] lat, input int nwords, input bit partial,
                       input bit tog, input string tag);
        bit cont = ls[1];
        bit lin = cont || nw;
        int n = cont ? nwords : (partial ? nwords : (ls == 2'b00 ? 4 : 8));
        int k = sa[2:0];
        int exp_wait = 0;
        logic [21:0] a = sa;
        for (int i = 0; i < n; i++) begin
            if (i > 0) begin
                if (lin) a = a + 22'd1;
                else if (ls == 2'b00) a = {a[21:2], a[1:0] + 2'd1};
                else a = {a[21:3], a[2:0] + 3'd1};
                if (lin && a[2:0] == 3'd0 && exp_wait == 0 && k != 0)
                    exp_wait = (lat < k) ? lat : k;
            end
            exp_q.push_back(a);
            tag_q.push_back(tag);
        end
        strict = !(cont || partial);
        adv_toggle = tog;
        wait_seen = 0;
        start_addr = sa; len_sel = ls; no_wrap = nw; latency = lat;
        start = 1'b1;
        @(negedge clk); #1;
        start = 1'b0;
        check(wait_n == 1'b1, "R1 first word wait_n", wait_n, 1);
        do begin @(negedge clk); #1; end while (exp_q.size() != 0);
        check(wait_seen == exp_wait, {tag, " stall cycles (R8/R9)"}, wait_seen, exp_wait);
        if (strict) begin
            @(negedge clk); #1;
            @(negedge clk); #1;
            check(valid == 1'b0, "R3 idle after burst", valid, 0);
        end
    endtask

    initial begin
        #1;
        check(valid == 1'b0 && wait_n == 1'b1 && addr == 22'd0, "R10 reset", addr, 0);
        #40 rst_n = 1'b1;
        @(negedge clk); #1;
        check(valid == 1'b0 && wait_n == 1'b1 && addr == 22'd0, "R10 after reset", {valid, wait_n}, 2'b01);
        mon_on = 1'b1;
        // R4 R5 wrap mode
        run(22'd1,  2'b00, 1'b0, 4'd4, 0, 1'b0, 1'b0, "R4 wrap4 start1");
        run(22'd5,  2'b00, 1'b0, 4'd4, 0, 1'b0, 1'b0, "R4 wrap4 start5");
        run(22'd13, 2'b01, 1'b0, 4'd7, 0, 1'b0, 1'b0, "R5 wrap8 start13");
        // R6 R8 linear fixed
        run(22'd2,  2'b00, 1'b1, 4'd4, 0, 1'b0, 1'b0, "R6 nowrap4 start2");
        run(22'd7,  2'b00, 1'b1, 4'd4, 0, 1'b0, 1'b0, "R8 nowrap4 start7");
        run(22'd15, 2'b00, 1'b1, 4'd9, 0, 1'b0, 1'b0, "R8 nowrap4 start15");
        run(22'd5,  2'b01, 1'b1, 4'd6, 0, 1'b0, 1'b0, "R8 nowrap8 start5");
        run(22'd3,  2'b01, 1'b1, 4'd0, 0, 1'b0, 1'b0, "R9 latency zero");
        run(22'd16, 2'b01, 1'b1, 4'd5, 0, 1'b0, 1'b0, "R9 aligned start");
        // R2 advance held low on alternate cycles
        run(22'd6,  2'b01, 1'b1, 4'd2, 0, 1'b0, 1'b1, "R2 toggled advance");
        // R7 continuous, two crossings, rollover, abort (R1)
        run(22'h20, 2'b10, 1'b0, 4'd5, 12, 1'b0, 1'b0, "R7 cont aligned");
        run(22'h33, 2'b11, 1'b0, 4'd7, 20, 1'b0, 1'b0, "R9 cont once");
        run(22'h3FFFFC, 2'b10, 1'b1, 4'd3, 8, 1'b0, 1'b0, "R7 rollover");
        run(22'd40, 2'b01, 1'b0, 4'd3, 3, 1'b1, 1'b0, "R1 abort part");
        run(22'd9,  2'b00, 1'b0, 4'd3, 0, 1'b0, 1'b0, "R1 after abort");
        mon_on = 1'b0;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule